// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog. Software loads a timeout period, starts the counter and must restart it before it reaches zero. If it does not, the block reacts in one of two ways. In direct mode the first expiry drives a system-reset pulse. In interrupt-first mode the first expiry raises an interrupt and reloads the counter. If that interrupt is still pending at the next expiry, the reset pulse follows.

A four-bit range code chooses the period. An elaboration parameter picks which table the code indexes. One table holds power-of-two periods. The other holds sixteen user-defined periods. A second parameter can lock the range code to its reset value, so that writes cannot change it. Software reaches the block through a small write port: a two-bit select and a six-bit data word. The current count is always visible on an output.

After a reset pulse the timer clears its own enable and stays frozen until software enables it again.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `irq_o` and `sys_rst_o` are low, `cnt_o` is zero and the timer is disabled.
- R2: In direct mode (mode bit 0), an expiry drives `sys_rst_o` high in the P-th cycle after the edge that loaded the counter, where P is the selected period. `irq_o` stays low throughout.
- R3: In interrupt-first mode (mode bit 1), the first expiry sets `irq_o` and reloads the counter. If `irq_o` is still set at the next expiry, `sys_rst_o` rises and `irq_o` drops.
- R4: An interrupt-clear write drops `irq_o` and reloads the counter with P-1. The next expiry then counts as a first expiry again.
- R5: A restart write reloads the counter with P-1 and leaves `irq_o` unchanged.
- R6: With `FIXED_TABLE`=1, range code i selects a period of 2^(FIX_SHIFT+i) cycles (2^(16+i) by default).
- R7: With `FIXED_TABLE`=0, range code i selects the 32-bit entry at bits [32i+31:32i] of `USER_PERIODS`. Each entry must lie between 2^8 and 2^CNT_W-1.
- R8: The reset pulse lasts exactly `RST_LEN` cycles. The same expiry clears the enable, and `cnt_o` then holds its value until the timer is enabled again.
- R9: While disabled, `cnt_o` holds and restart writes have no effect. A write that sets enable from low loads P-1, using the range code carried in that same write.
- R10: A range-code write while the timer runs does not alter the count in progress. The new period applies from the next reload.
- R11: With `HARD_RANGE`=1, written range codes are ignored and code `RANGE_RST` is always used.
- R12: Write encoding. Select 0 is control: data bit 0 is enable, bit 1 is mode, bits [5:2] are the range code. Select 1 is restart. Select 2 is interrupt clear. Select 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 6 | Write data (control fields) |
| irq_o | output | 1 | Watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse |
| cnt_o | output | CNT_W | Current counter value |

## Verification
The bench measures the exact cycle of each expiry from the edge that loaded the counter, so an off-by-one reload value shows up as a shifted event. It leaves an interrupt pending to confirm escalation, and clears one to confirm the timer starts over at the first stage. A design that reloaded on clear but kept the pending flag would reset too early. It restarts the timer while an interrupt is pending; a design whose restart also cleared the interrupt would never escalate. It changes the range code mid-count, which catches a design that reloads at once or keeps the old period after the reload. It also writes to a disabled timer, to the unused select and to a locked range code, where any visible change in the count is an error.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int              CNT_W        = 32,
  parameter int              FIXED_TABLE  = 1,
  parameter int              FIX_SHIFT    = 16,
  parameter logic [511:0]    USER_PERIODS = {16{32'd4096}},
  parameter int              HARD_RANGE   = 0,
  parameter int              RANGE_RST    = 0,
  parameter int              RST_LEN      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [5:0]       wr_data,
  output logic             irq_o,
  output logic             sys_rst_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int         PW       = $clog2(RST_LEN + 1);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_KICK = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  logic             en_q, mode_q, irq_q;
  logic [3:0]       range_q, range_d;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pcnt_q;

  function automatic logic [CNT_W-1:0] reload_of(input logic [3:0] code);
    logic [CNT_W:0] p;
    if (FIXED_TABLE != 0) p = (CNT_W+1)'(1) << (FIX_SHIFT + int'(code));
    else                  p = (CNT_W+1)'(USER_PERIODS[int'(code)*32 +: 32]);
    return CNT_W'(p - 1'b1);
  endfunction

  wire ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  wire kick_wr  = wr_en && (wr_sel == SEL_KICK);
  wire clr_wr   = wr_en && (wr_sel == SEL_CLR);
  wire en_d     = ctrl_wr ? wr_data[0] : en_q;
  wire mode_d   = ctrl_wr ? wr_data[1] : mode_q;
  wire start    = ctrl_wr && wr_data[0] && !en_q;
  wire expire   = en_q && en_d && (cnt_q == '0) && !kick_wr && !clr_wr;
  wire escalate = expire && (!mode_q || irq_q);
  wire reload   = start || (en_q && en_d && (kick_wr || clr_wr)) || (expire && !escalate);

  generate
    if (HARD_RANGE != 0) begin : g_hard
      assign range_q = 4'(RANGE_RST);
      assign range_d = 4'(RANGE_RST);
    end else begin : g_soft
      assign range_d = ctrl_wr ? wr_data[5:2] : range_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) range_q <= 4'(RANGE_RST);
        else        range_q <= range_d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      en_q   <= escalate ? 1'b0 : en_d;
      mode_q <= mode_d;
      if (escalate || clr_wr) irq_q <= 1'b0;
      else if (expire)        irq_q <= 1'b1;
      if (reload)                             cnt_q <= reload_of(range_d);
      else if (en_q && en_d && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (escalate)            pcnt_q <= PW'(RST_LEN);
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = (pcnt_q != '0);
  assign cnt_o     = cnt_q;

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cnt_q == '0 && en_q && mode_q));                 // R3
  AST_RST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(cnt_q == '0 && en_q));                       // R2
  AST_HALT_ON_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> !en_q);                                            // R8
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> $stable(cnt_o));                            // R9
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && en_q && $past(cnt_q) != '0 && !$past(wr_en))
      |-> cnt_o == $past(cnt_q) - 1'b1);                                    // R10

endmodule

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;

  function automatic logic [511:0] mk_tab();
    logic [511:0] t;
    for (int i = 0; i < 16; i++) t[i*32 +: 32] = 32'(256 + 32*i);
    return t;
  endfunction
  localparam logic [511:0] TAB = mk_tab();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] we = '0;
  logic [1:0] sel = '0;
  logic [5:0] dat = '0;
  logic irq0, rst0, irq1, rst1, irq2, rst2;
  logic [15:0] cnt0, cnt2;
  logic [19:0] cnt1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(16), .FIXED_TABLE(0), .USER_PERIODS(TAB), .RST_LEN(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_sel(sel), .wr_data(dat),
    .irq_o(irq0), .sys_rst_o(rst0), .cnt_o(cnt0));
  wdog_timer #(.CNT_W(20), .FIXED_TABLE(1), .FIX_SHIFT(4), .RST_LEN(4)) u_fix (
    .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_sel(sel), .wr_data(dat),
    .irq_o(irq1), .sys_rst_o(rst1), .cnt_o(cnt1));
  wdog_timer #(.CNT_W(16), .FIXED_TABLE(0), .USER_PERIODS(TAB), .HARD_RANGE(1),
               .RANGE_RST(5), .RST_LEN(4)) u_hard (
    .clk(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_sel(sel), .wr_data(dat),
    .irq_o(irq2), .sys_rst_o(rst2), .cnt_o(cnt2));

  function automatic int g_irq(int i);
    return i == 0 ? int'(irq0) : i == 1 ? int'(irq1) : int'(irq2);
  endfunction
  function automatic int g_rst(int i);
    return i == 0 ? int'(rst0) : i == 1 ? int'(rst1) : int'(rst2);
  endfunction
  function automatic int g_cnt(int i);
    return i == 0 ? int'(cnt0) : i == 1 ? int'(cnt1) : int'(cnt2);
  endfunction
  function automatic logic [5:0] ctl(int code, int mode, int en);
    return {4'(code), 1'(mode), 1'(en)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int i, logic [1:0] s, logic [5:0] d);
    @(negedge clk);
    we[i] = 1'b1; sel = s; dat = d;
    @(negedge clk);
    we = '0;
  endtask

  task automatic wait_evt(int i, bit want_rst, output int n, output int irq_seen);
    n = 0; irq_seen = 0;
    forever begin
      @(negedge clk);
      n++;
      if (g_irq(i) != 0 && want_rst == 0) break;
      if (g_irq(i) != 0) irq_seen = 1;
      if (g_rst(i) != 0 || n >= 5000) break;
    end
  endtask

  task automatic t_reset();
    chk("R1 irq", g_irq(0), 0);
    chk("R1 rst", g_rst(0), 0);
    chk("R1 cnt", g_cnt(0), 0);
  endtask

  task automatic t_direct();
    int n, s, w;
    wr(0, 2'd0, ctl(0, 0, 1));
    chk("R9 load", g_cnt(0), 255);
    wait_evt(0, 1, n, s);
    chk("R2 rst time", n, 256);
    chk("R2 no irq", s, 0);
    w = 0;
    while (g_rst(0) != 0 && w < 100) begin w++; @(negedge clk); end
    chk("R8 pulse width", w, 6);
    repeat (40) @(negedge clk);
    chk("R8 frozen", g_cnt(0), 0);
    chk("R8 no rst", g_rst(0), 0);
    wr(0, 2'd1, 6'd0);
    repeat (5) @(negedge clk);
    chk("R9 kick ignored", g_cnt(0), 0);
  endtask

  task automatic t_two_stage();
    int n, s;
    wr(0, 2'd0, ctl(2, 1, 1));
    wait_evt(0, 0, n, s);
    chk("R3 irq time", n, 320);
    chk("R3 no rst yet", g_rst(0), 0);
    chk("R3 reload", g_cnt(0), 319);
    wait_evt(0, 1, n, s);
    chk("R3 rst time", n, 320);
    chk("R3 irq held", s, 1);
    chk("R3 irq dropped", g_irq(0), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_clear();
    int n, s;
    wr(0, 2'd0, ctl(1, 1, 1));
    wait_evt(0, 0, n, s);
    chk("R3 irq time c1", n, 288);
    wr(0, 2'd2, 6'd0);
    chk("R4 irq cleared", g_irq(0), 0);
    chk("R4 reload", g_cnt(0), 287);
    wait_evt(0, 0, n, s);
    chk("R4 first again", n, 288);
    chk("R4 no rst", g_rst(0), 0);
    wr(0, 2'd2, 6'd0);
    wr(0, 2'd0, ctl(1, 1, 0));
  endtask

  task automatic t_kick();
    int n, s;
    wr(0, 2'd0, ctl(0, 1, 1));
    repeat (100) @(negedge clk);
    wr(0, 2'd1, 6'd0);
    chk("R5 kick reload", g_cnt(0), 255);
    wait_evt(0, 0, n, s);
    chk("R5 irq after kick", n, 256);
    wr(0, 2'd1, 6'd0);
    chk("R5 irq kept", g_irq(0), 1);
    chk("R5 kick reload2", g_cnt(0), 255);
    wr(0, 2'd2, 6'd0);
    wr(0, 2'd0, ctl(0, 1, 0));
  endtask

  task automatic t_hold_and_range();
    int c, n, s;
    wr(0, 2'd0, ctl(0, 1, 1));
    repeat (20) @(negedge clk);
    wr(0, 2'd0, ctl(0, 1, 0));
    c = g_cnt(0);
    repeat (50) @(negedge clk);
    chk("R9 hold", g_cnt(0), c);
    wr(0, 2'd1, 6'd0);
    chk("R9 kick while off", g_cnt(0), c);
    wr(0, 2'd3, 6'h3F);
    repeat (3) @(negedge clk);
    chk("R12 sel3 cnt", g_cnt(0), c);
    chk("R12 sel3 irq", g_irq(0), 0);
    wr(0, 2'd0, ctl(15, 1, 1));
    chk("R7 code15 load", g_cnt(0), 735);
    wr(0, 2'd0, ctl(0, 1, 1));
    chk("R10 no mid reload", g_cnt(0), 733);
    wait_evt(0, 0, n, s);
    chk("R10 old period", n, 734);
    chk("R10 new period at reload", g_cnt(0), 255);
    wr(0, 2'd2, 6'd0);
    wr(0, 2'd0, ctl(0, 1, 0));
  endtask

  task automatic t_fixed();
    int n, s;
    wr(1, 2'd0, ctl(0, 0, 1));
    chk("R6 code0 load", g_cnt(1), 15);
    wait_evt(1, 1, n, s);
    chk("R6 code0 time", n, 16);
    repeat (10) @(negedge clk);
    wr(1, 2'd0, ctl(3, 0, 1));
    chk("R6 code3 load", g_cnt(1), 127);
    wait_evt(1, 1, n, s);
    chk("R6 code3 time", n, 128);
  endtask

  task automatic t_hard();
    int n, s;
    wr(2, 2'd0, ctl(0, 0, 1));
    chk("R11 locked load", g_cnt(2), 415);
    wait_evt(2, 1, n, s);
    chk("R11 locked time", n, 416);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_direct();
    t_two_stage();
    t_clear();
    t_kick();
    t_hold_and_range();
    t_fixed();
    t_hard();
    done = 1;
    finish_run();
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule